// File: doc/BRIEF.md
# DRAM Strobe Timing Sequencer

This block produces the active-low row strobe, the active-low column strobe and a column-address-select signal for a single access or a single refresh on an asynchronous DRAM. It runs from a clock at twice the memory clock. Each period of that clock is one tick, which is half a memory clock. Every delay, strobe width and precharge interval is a whole number of ticks, so settings of 1.5 memory clocks are exact.

A controller sets the cycle type, the memory type (extended-data-out or fast-page), the row-to-column delay select, the precharge code and the random-cycle count. It then raises `start` while `busy` is low. The block latches those settings, runs the strobe sequence and pulses `done` once precharge is over. The timing rules depend on the memory type and on the precharge setting, and one combination forces a longer row-to-column delay.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset, `ras_n` and `cas_n` are high, `col_sel`, `busy`, `done` and `cfg_err` are low.
- R2: `start` is accepted only while `busy` is low. A `start` raised during a running cycle has no effect: no extra row strobe follows the `done` pulse.
- R3: `ras_n` falls on the tick after the accepting edge. `cas_n` falls D ticks after `ras_n` falls. D = 4 when `rcd_sel` = 0 and D = 2 when `rcd_sel` = 1.
- R4: With `is_edo` = 1 and `rp_code` = 01, D is 4 regardless of `rcd_sel`.
- R5: `cas_n` stays low for C ticks. For extended-data-out memory, C = D, except C = 3 when `rp_code` = 01. For fast-page memory, C = D + 1, except C = D when `rp_code` = 01.
- R6: Precharge P in ticks is 4 for `rp_code` 00, 3 for 01 and 2 for 10. Code 11 is treated as 4 and raises `cfg_err` for one tick, in the same tick as `ras_n` falls.
- R7: For an access, `ras_n` stays low for max(2*`rc_count` - P, D + C) ticks.
- R8: For a refresh (`is_refresh` = 1), `cas_n` stays high and `col_sel` stays low. `ras_n` stays low for P + 1 ticks with fast-page memory and `rp_code` other than 01, and for P ticks otherwise.
- R9: After `ras_n` rises it stays high for P ticks. `done` is then high for exactly one tick, and `busy` falls on the following tick. `busy` is high from the fall of `ras_n` through the `done` tick.
- R10: `col_sel` rises one tick before `cas_n` falls and falls in the same tick as `cas_n` rises (with the default `COL_LEAD` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Tick clock, twice the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one cycle |
| is_refresh | input | 1 | 1 = refresh cycle, 0 = access |
| is_edo | input | 1 | 1 = extended-data-out memory, 0 = fast-page |
| rcd_sel | input | 1 | Row-to-column delay select (0 = 2 clocks, 1 = 1 clock) |
| rp_code | input | 2 | Precharge width code |
| rc_count | input | RC_W | Random-cycle length in memory clocks |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| col_sel | output | 1 | Column address select |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-tick end-of-cycle pulse |
| cfg_err | output | 1 | Reserved precharge code seen |

## Verification
The bench covers all four memory-type and precharge-half combinations. A design that ignored the forced override would drop the column strobe two ticks early on extended-data-out memory with 1.5-clock precharge. One that mixed up the half-clock add-ons would make strobe widths off by one tick. Refresh cycles check that the column strobe stays quiet and that only fast-page refreshes gain the extra half clock. Other tests cover a cycle count short enough that the delay-plus-column minimum sets the row strobe width, the reserved precharge code with its error pulse, and a start raised mid-cycle that a faulty design would turn into a second row strobe.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROW  = 2'd1,
      ST_PRE  = 2'd2,
      ST_FIN  = 2'd3
   } seq_state_t;

   localparam logic [1:0] RP_FULL2 = 2'b00;
   localparam logic [1:0] RP_HALF3 = 2'b01;
   localparam logic [1:0] RP_FULL1 = 2'b10;
   localparam logic [1:0] RP_RSVD  = 2'b11;
endpackage

// File: rtl/dram_timing_calc.sv
module dram_timing_calc
   import dram_strobe_pkg::*;
#(
   parameter int RC_W  = 4,
   parameter int LEN_W = RC_W + 2
) (
   input  logic             is_refresh,
   input  logic             is_edo,
   input  logic             rcd_sel,
   input  logic [1:0]       rp_code,
   input  logic [RC_W-1:0]  rc_count,
   output logic [LEN_W-1:0] rcd_ticks,
   output logic [LEN_W-1:0] cas_ticks,
   output logic [LEN_W-1:0] row_ticks,
   output logic [LEN_W-1:0] pre_ticks,
   output logic             rp_bad
);
   logic             half_pre;
   logic             long_rcd;
   logic [LEN_W-1:0] two_rc;
   logic [LEN_W-1:0] min_row;
   logic [LEN_W-1:0] ref_row;
   logic [LEN_W-1:0] acc_row;

   always_comb begin
      half_pre = (rp_code == RP_HALF3);
      rp_bad   = (rp_code == RP_RSVD);
      unique case (rp_code)
         RP_HALF3: pre_ticks = LEN_W'(3);
         RP_FULL1: pre_ticks = LEN_W'(2);
         default:  pre_ticks = LEN_W'(4);
      endcase
      long_rcd  = !rcd_sel || (is_edo && half_pre);
      rcd_ticks = long_rcd ? LEN_W'(4) : LEN_W'(2);
      if (is_edo)
         cas_ticks = half_pre ? LEN_W'(3) : rcd_ticks;
      else
         cas_ticks = half_pre ? rcd_ticks : rcd_ticks + LEN_W'(1);
      ref_row = pre_ticks + ((!is_edo && !half_pre) ? LEN_W'(1) : LEN_W'(0));
      two_rc  = LEN_W'({rc_count, 1'b0});
      min_row = rcd_ticks + cas_ticks;
      acc_row = (two_rc >= pre_ticks + min_row) ? two_rc - pre_ticks : min_row;
      row_ticks = is_refresh ? ref_row : acc_row;
   end
endmodule

// File: rtl/dram_strobe_fsm.sv
module dram_strobe_fsm
   import dram_strobe_pkg::*;
#(
   parameter int LEN_W    = 6,
   parameter int COL_LEAD = 1
) (
   input  logic             clk2x,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_refresh,
   input  logic [LEN_W-1:0] rcd_ticks,
   input  logic [LEN_W-1:0] cas_ticks,
   input  logic [LEN_W-1:0] row_ticks,
   input  logic [LEN_W-1:0] pre_ticks,
   input  logic             rp_bad,
   output logic             ras_n,
   output logic             cas_n,
   output logic             col_sel,
   output logic             busy,
   output logic             done,
   output logic             cfg_err
);
   seq_state_t       state;
   logic [LEN_W-1:0] tick;
   logic [LEN_W-1:0] rcd_q, cas_q, row_q, pre_q;
   logic             ref_q, err_q;
   logic             in_cas, in_col;
   logic [LEN_W-1:0] cas_end;

   always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tick  <= '0;
         rcd_q <= '0;
         cas_q <= '0;
         row_q <= '0;
         pre_q <= '0;
         ref_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_ROW;
               tick  <= '0;
               rcd_q <= rcd_ticks;
               cas_q <= cas_ticks;
               row_q <= row_ticks;
               pre_q <= pre_ticks;
               ref_q <= is_refresh;
               err_q <= rp_bad;
            end
            ST_ROW: if (tick == row_q - LEN_W'(1)) begin
               state <= ST_PRE;
               tick  <= '0;
            end else begin
               tick <= tick + LEN_W'(1);
            end
            ST_PRE: if (tick == pre_q - LEN_W'(1)) begin
               state <= ST_FIN;
               tick  <= '0;
            end else begin
               tick <= tick + LEN_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cas_end = rcd_q + cas_q;
   assign in_cas  = (state == ST_ROW) && !ref_q && (tick >= rcd_q) && (tick < cas_end);

   generate
      if (COL_LEAD != 0) begin : g_col_lead
         assign in_col = (state == ST_ROW) && !ref_q
                         && (tick >= rcd_q - LEN_W'(1)) && (tick < cas_end);
      end else begin : g_col_align
         assign in_col = in_cas;
      end
   endgenerate

   assign ras_n   = (state != ST_ROW);
   assign cas_n   = !in_cas;
   assign col_sel = in_col;
   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_FIN);
   assign cfg_err = err_q;
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
   import dram_strobe_pkg::*;
#(
   parameter int RC_W     = 4,
   parameter int COL_LEAD = 1
) (
   input  logic            clk2x,
   input  logic            rst_n,
   input  logic            start,
   input  logic            is_refresh,
   input  logic            is_edo,
   input  logic            rcd_sel,
   input  logic [1:0]      rp_code,
   input  logic [RC_W-1:0] rc_count,
   output logic            ras_n,
   output logic            cas_n,
   output logic            col_sel,
   output logic            busy,
   output logic            done,
   output logic            cfg_err
);
   localparam int LEN_W = RC_W + 2;

   generate
      if (RC_W < 2 || RC_W > 8) begin : g_bad_rcw
         $error("dram_strobe_seq: RC_W must be 2..8");
      end
      if (COL_LEAD != 0 && COL_LEAD != 1) begin : g_bad_lead
         $error("dram_strobe_seq: COL_LEAD must be 0 or 1");
      end
   endgenerate

   logic [LEN_W-1:0] rcd_ticks, cas_ticks, row_ticks, pre_ticks;
   logic             rp_bad;

   dram_timing_calc #(.RC_W(RC_W), .LEN_W(LEN_W)) i_calc (
      .is_refresh (is_refresh),
      .is_edo     (is_edo),
      .rcd_sel    (rcd_sel),
      .rp_code    (rp_code),
      .rc_count   (rc_count),
      .rcd_ticks  (rcd_ticks),
      .cas_ticks  (cas_ticks),
      .row_ticks  (row_ticks),
      .pre_ticks  (pre_ticks),
      .rp_bad     (rp_bad)
   );

   dram_strobe_fsm #(.LEN_W(LEN_W), .COL_LEAD(COL_LEAD)) i_fsm (
      .clk2x      (clk2x),
      .rst_n      (rst_n),
      .start      (start),
      .is_refresh (is_refresh),
      .rcd_ticks  (rcd_ticks),
      .cas_ticks  (cas_ticks),
      .row_ticks  (row_ticks),
      .pre_ticks  (pre_ticks),
      .rp_bad     (rp_bad),
      .ras_n      (ras_n),
      .cas_n      (cas_n),
      .col_sel    (col_sel),
      .busy       (busy),
      .done       (done),
      .cfg_err    (cfg_err)
   );
endmodule

// File: rtl/dram_strobe_seq_chk.sv
module dram_strobe_seq_chk #(
   parameter int COL_LEAD = 1
) (
   input logic clk2x,
   input logic rst_n,
   input logic start,
   input logic ras_n,
   input logic cas_n,
   input logic col_sel,
   input logic busy,
   input logic done,
   input logic cfg_err
);
   p_idle_quiet_r1: assert property (@(posedge clk2x) disable iff (!rst_n)
      !busy |-> (ras_n && cas_n && !col_sel && !done));

   p_hold_busy_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_ras_after_accept_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
      (!busy && start) |=> (!ras_n && busy));

   p_cas_within_ras_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   p_err_at_ras_fall_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
      cfg_err |-> $fell(ras_n));

   p_done_single_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_done_strobes_high_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
      done |-> (ras_n && cas_n && $past(ras_n)));

   p_col_covers_cas_r10: assert property (@(posedge clk2x) disable iff (!rst_n)
      !cas_n |-> col_sel);

   generate
      if (COL_LEAD != 0) begin : g_lead_chk
         p_col_leads_r10: assert property (@(posedge clk2x) disable iff (!rst_n)
            $fell(cas_n) |-> $past(col_sel));
      end
   endgenerate
endmodule

bind dram_strobe_seq dram_strobe_seq_chk #(.COL_LEAD(COL_LEAD)) i_chk (
   .clk2x   (clk2x),
   .rst_n   (rst_n),
   .start   (start),
   .ras_n   (ras_n),
   .cas_n   (cas_n),
   .col_sel (col_sel),
   .busy    (busy),
   .done    (done),
   .cfg_err (cfg_err)
);

// File: tb/test_dram_strobe_seq.sv
`timescale 1ns/100ps
module test_dram_strobe_seq;
   logic       clk2x = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       is_refresh = 1'b0;
   logic       is_edo = 1'b0;
   logic       rcd_sel = 1'b0;
   logic [1:0] rp_code = 2'b00;
   logic [3:0] rc_count = 4'd4;
   logic       ras_n, cas_n, col_sel, busy, done, cfg_err;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk2x = ~clk2x;

   dram_strobe_seq i_dram_strobe_seq (
      .clk2x(clk2x), .rst_n(rst_n), .start(start), .is_refresh(is_refresh),
      .is_edo(is_edo), .rcd_sel(rcd_sel), .rp_code(rp_code), .rc_count(rc_count),
      .ras_n(ras_n), .cas_n(cas_n), .col_sel(col_sel), .busy(busy),
      .done(done), .cfg_err(cfg_err)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk2x);
      check("R1", "ras_n in reset", int'(ras_n), 1);
      check("R1", "cas_n in reset", int'(cas_n), 1);
      check("R1", "col/busy/done/err in reset",
            int'({col_sel, busy, done, cfg_err}), 0);
      rst_n = 1'b1;
      @(negedge clk2x);
      check("R1", "busy after reset", int'(busy), 0);
      check("R1", "ras_n after reset", int'(ras_n), 1);
   endtask

   // Runs one cycle and checks every strobe edge against the rules.
   // inj > 0 raises start again at that tick to test the ignore rule.
   task automatic run_cycle(string tag, bit refr, bit edo, bit sel,
                            logic [1:0] rp, int rc, int inj);
      int p, d, c, row, hd;
      int ras_first = 0, ras_cnt = 0, cas_first = 0, cas_cnt = 0;
      int col_first = 0, col_cnt = 0, done_n = 0, done_cnt = 0;
      int err_n = 0, err_cnt = 0, busy_after = -1, ras_late = 0;
      p  = (rp == 2'b01) ? 3 : (rp == 2'b10) ? 2 : 4;
      hd = (rp == 2'b01);
      d  = (!sel || (edo && hd)) ? 4 : 2;
      if (edo) c = hd ? 3 : d;
      else     c = hd ? d : d + 1;
      if (refr) row = p + ((!edo && !hd) ? 1 : 0);
      else      row = (2*rc - p > d + c) ? 2*rc - p : d + c;

      @(negedge clk2x);
      is_refresh = refr; is_edo = edo; rcd_sel = sel;
      rp_code = rp; rc_count = 4'(rc); start = 1'b1;
      for (int n = 1; n <= 70; n++) begin
         @(negedge clk2x);
         if (n == 1) start = 1'b0;
         if (inj > 0 && n == inj) start = 1'b1;
         if (inj > 0 && n == inj + 1) start = 1'b0;
         if (!ras_n) begin
            if (ras_first == 0) ras_first = n;
            ras_cnt++;
            if (done_n != 0) ras_late++;
         end
         if (!cas_n) begin
            if (cas_first == 0) cas_first = n;
            cas_cnt++;
         end
         if (col_sel) begin
            if (col_first == 0) col_first = n;
            col_cnt++;
         end
         if (done) begin
            if (done_n == 0) done_n = n;
            done_cnt++;
         end
         if (cfg_err) begin
            if (err_n == 0) err_n = n;
            err_cnt++;
         end
         if (done_n != 0 && n == done_n + 1) busy_after = int'(busy);
      end

      check("R3", {tag, " ras fall tick"}, ras_first, 1);
      check(refr ? "R8" : "R7", {tag, " ras low width"}, ras_cnt, row);
      if (refr) begin
         check("R8", {tag, " cas quiet on refresh"}, cas_cnt, 0);
         check("R8", {tag, " col quiet on refresh"}, col_cnt, 0);
      end else begin
         check(hd && edo ? "R4" : "R3", {tag, " cas fall tick"}, cas_first, 1 + d);
         check("R5", {tag, " cas low width"}, cas_cnt, c);
         check("R10", {tag, " col rise tick"}, col_first, d);
         check("R10", {tag, " col width"}, col_cnt, c + 1);
      end
      check("R9", {tag, " done tick"}, done_n, row + p + 1);
      check("R9", {tag, " done width"}, done_cnt, 1);
      check("R9", {tag, " busy after done"}, busy_after, 0);
      check("R6", {tag, " err pulses"}, err_cnt, (rp == 2'b11) ? 1 : 0);
      if (rp == 2'b11) check("R6", {tag, " err tick"}, err_n, 1);
      if (inj > 0) check("R2", {tag, " no second row strobe"}, ras_late, 0);
   endtask

   task automatic t_access_edo();
      run_cycle("edo rp2 long", 1'b0, 1'b1, 1'b0, 2'b00, 4, 0);
      run_cycle("edo rp1 rc8", 1'b0, 1'b1, 1'b1, 2'b10, 8, 0);
   endtask

   task automatic t_forced_delay();
      run_cycle("edo half forced", 1'b0, 1'b1, 1'b1, 2'b01, 4, 0);
   endtask

   task automatic t_access_fpm();
      run_cycle("fpm rp1 short rc", 1'b0, 1'b0, 1'b1, 2'b10, 3, 0);
      run_cycle("fpm half rc5", 1'b0, 1'b0, 1'b1, 2'b01, 5, 0);
      run_cycle("fpm rp2 long", 1'b0, 1'b0, 1'b0, 2'b00, 12, 0);
   endtask

   task automatic t_reserved();
      run_cycle("fpm reserved rp", 1'b0, 1'b0, 1'b1, 2'b11, 6, 0);
   endtask

   task automatic t_refresh();
      run_cycle("ref fpm rp2", 1'b1, 1'b0, 1'b0, 2'b00, 4, 0);
      run_cycle("ref edo half", 1'b1, 1'b1, 1'b0, 2'b01, 4, 0);
      run_cycle("ref fpm half", 1'b1, 1'b0, 1'b1, 2'b01, 4, 0);
      run_cycle("ref edo rp1", 1'b1, 1'b1, 1'b1, 2'b10, 4, 0);
   endtask

   task automatic t_ignore_start();
      run_cycle("start while busy", 1'b0, 1'b1, 1'b1, 2'b00, 5, 3);
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_access_edo();
      t_forced_delay();
      t_access_fpm();
      t_reserved();
      t_refresh();
      t_ignore_start();
      repeat (4) @(negedge clk2x);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule